// File: doc/BRIEF.md
# Byte-Wide Host Register Port

This block lets an 8-bit host processor reach a 16-bit internal address space through four host-visible registers. The host selects a register with a 2-bit select, uses an active-low chip select and a read/not-write line, and waits for an active-low ready before ending the cycle. Two of the registers hold the low and high bytes of an index address. The other two read or write the internal location that the index points at. One of them leaves the index alone. The other moves the index forward by one after each access.

A DMA mode, chosen by an active-low select pin, ignores the register-select pins. It then uses a separate DMA address that lives in the internal space. A control bit picks whether that DMA address steps forward after each access. Statistics counters, each 32 bits wide, are read one byte at a time. Reading the lowest byte of a counter copies the whole counter into a holding register, so the higher bytes always belong to the same sample.

A host write through the data registers to the index range 0x4000 to 0x5FFF starts a fixed-length reset of the whole core. The internal register space outside the counters is a small memory stub.

Top module: `hostbyte_port`

## Requirements
- R1: A write to select 00 sets bits 7:0 of the index address and a write to select 01 sets bits 15:8. Reads of 00 and 01 return those bytes.
- R2: Select 10 reads or writes the internal location at the index address and leaves the index unchanged. Memory stub locations 0x0000 to 0x003F are read/write and hold the last byte written.
- R3: Select 11 reads or writes the location at the index address, then adds one to the index. The index wraps from 0xFFFF to 0x0000.
- R4: With the DMA select low, the select pins are ignored, the access uses the DMA address, and the index address is not changed. With control bit 0 of location 0x0040 at 0, the DMA address does not change.
- R5: With control bit 0 of 0x0040 at 1, each DMA access adds one to the DMA address. The DMA address is held at 0x0041 (low byte) and 0x0042 (high byte).
- R6: Counter n occupies 0x8000+4n to 0x8003+4n, with byte k holding bits 8k+7:8k. Reading byte 0 returns the live low byte and copies the whole counter into a holding register. Bytes 1 to 3 return the holding copy. Host writes to counters have no effect.
- R7: A non-DMA write through select 10 or 11 to an index in 0x4000 to 0x5FFF drives core_rst_n low for exactly 16 clocks, starting the clock after the access. All registers, the memory stub and the counters return to zero.
- R8: A DMA write to a DMA address in 0x4000 to 0x5FFF causes no reset and completes with a normal ready.
- R9: The clock after an access starts, ready is driven low for one clock, with read data driven on the bus for reads. On the next clock ready is driven high and the data bus is released. After that, ready is released once chip select is high.
- R10: While the hardware reset or the generated reset is active, the data bus and ready are not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cs_n | input | 1 | Host chip select, active low |
| rnw | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 2 | Host register select |
| dma_sel_n | input | 1 | DMA mode select, active low |
| host_d_i | input | 8 | Write data from the host |
| host_d_o | output | 8 | Read data to the host |
| host_d_oe | output | 1 | Drive enable for host_d_o |
| rdy_n_o | output | 1 | Ready value, active low |
| rdy_oe | output | 1 | Drive enable for ready |
| cnt_inc | input | NUM_CNT | One-clock increment strobes for the counters |
| core_rst_n | output | 1 | Core reset, hardware reset combined with the generated pulse |

## Verification
The bench goes after the snapshot. It reads a counter's byte 0, advances the counter past a byte boundary, and then reads byte 1. A design that returned live bytes would then show the new carry. It also checks index wrap at 0xFFFF, where a design with a narrow or saturating incrementer would stop at 0xFFFF or spill into garbage. The tests also cover DMA accesses that put pin values on the select lines that would move the index if they were decoded. Two more tests put host and DMA writes into the reset window: a design that got the gating wrong would either reset on a DMA write or miss the host one. The reset-pulse length is counted to the clock.

// File: rtl/hbp_pkg.sv
// Shared types for the byte-wide host register port.
// Assumes a 16-bit internal address reached through two index bytes.
package hbp_pkg;
    localparam int HBP_AW = 16;

    typedef enum logic [1:0] {
        SEL_ALO  = 2'b00,
        SEL_AHI  = 2'b01,
        SEL_DATA = 2'b10,
        SEL_DINC = 2'b11
    } hsel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_HIGH = 2'd2,
        ST_WAIT = 2'd3
    } bus_st_e;
endpackage

// File: rtl/hbp_bus_fsm.sv
// Host bus handshake sequencer.
// Starts one access per chip-select assertion, then drives ready low for one
// clock, high for one clock, and releases it. It assumes the host inputs are
// synchronous to clk and stable while cs_n is low. After reset it waits for
// cs_n to go high, so an access that was cut short by reset is not repeated.
module hbp_bus_fsm
    import hbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rnw,
    output logic acc_go,
    output logic rdy_n_o,
    output logic rdy_oe,
    output logic data_oe
);
    bus_st_e st_q;
    logic    rnw_q;

    assign acc_go = (st_q == ST_IDLE) && !cs_n;

    // Purpose: advance the handshake states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_WAIT;
        end else begin
            unique case (st_q)
                ST_IDLE: if (!cs_n) st_q <= ST_ACK;
                ST_ACK:  st_q <= ST_HIGH;
                ST_HIGH: st_q <= cs_n ? ST_IDLE : ST_WAIT;
                ST_WAIT: if (cs_n) st_q <= ST_IDLE;
                default: st_q <= ST_WAIT;
            endcase
        end
    end

    // Purpose: remember the direction of the access in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)      rnw_q <= 1'b0;
        else if (acc_go) rnw_q <= rnw;
    end

    // Purpose: bus drive enables and ready level, all off during reset.
    always_comb begin
        rdy_oe  = rst_n && ((st_q == ST_ACK) || (st_q == ST_HIGH));
        rdy_n_o = (st_q != ST_ACK);
        data_oe = rst_n && (st_q == ST_ACK) && rnw_q;
    end

    AST_ACK_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe && !rdy_n_o) |=> (rdy_oe && rdy_n_o && !data_oe)); // R9
    AST_START_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> (rdy_oe && !rdy_n_o)); // R9
endmodule

// File: rtl/hbp_reset_gen.sv
// Generated reset pulse.
// A trigger starts a core reset lasting PULSE_LEN clocks. Only the hardware
// reset clears this counter, so the pulse always runs to completion.
module hbp_reset_gen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic core_rst_n
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt_q;

    // Purpose: load the pulse length on a trigger and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
        else if (trig)            cnt_q <= CW'(PULSE_LEN);
    end

    assign core_rst_n = rst_n && (cnt_q == '0);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && core_rst_n) |=> !core_rst_n); // R7
endmodule

// File: rtl/hbp_regspace.sv
// Internal register space behind the host port.
// It holds a read/write memory stub at the bottom of the space, a control
// byte, a DMA address pair, and read-only statistics counters with a
// byte-0 snapshot holding register. Reads are combinational and writes take
// effect on the clock where wr_en is high. It assumes CNT_W/8 and NUM_CNT are
// powers of two and NUM_CNT >= 2.
module hbp_regspace
    import hbp_pkg::*;
#(
    parameter int MEM_DEPTH = 64,
    parameter int CTRL_ADDR = 'h0040,
    parameter int STAT_BASE = 'h8000,
    parameter int NUM_CNT   = 4,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [HBP_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              dma_step,
    output logic              dma_inc,
    output logic [HBP_AW-1:0] dma_addr,
    input  logic [NUM_CNT-1:0] cnt_inc
);
    localparam int MEM_AW    = $clog2(MEM_DEPTH);
    localparam int CNT_BYTES = CNT_W / 8;
    localparam int BSEL_W    = $clog2(CNT_BYTES);
    localparam int CIDX_W    = $clog2(NUM_CNT);
    localparam int STAT_SPAN = NUM_CNT * CNT_BYTES;
    localparam logic [HBP_AW-1:0] A_CTRL  = HBP_AW'(CTRL_ADDR);
    localparam logic [HBP_AW-1:0] A_DLO   = HBP_AW'(CTRL_ADDR + 1);
    localparam logic [HBP_AW-1:0] A_DHI   = HBP_AW'(CTRL_ADDR + 2);
    localparam logic [HBP_AW-1:0] A_STAT  = HBP_AW'(STAT_BASE);
    localparam logic [HBP_AW-1:0] A_STEND = HBP_AW'(STAT_BASE + STAT_SPAN);
    localparam logic [HBP_AW-1:0] A_MEND  = HBP_AW'(MEM_DEPTH);

    logic [7:0]        mem_q [MEM_DEPTH];
    logic [CNT_W-1:0]  cnt_q [NUM_CNT];
    logic [CNT_W-1:0]  hold_q;
    logic              inc_q;
    logic [HBP_AW-1:0] dma_q;

    logic              in_mem, in_stat, snap_ld;
    logic [HBP_AW-1:0] off;
    logic [CIDX_W-1:0] cidx;
    logic [BSEL_W-1:0] bsel;

    // Purpose: decode which region the address falls in.
    always_comb begin
        in_mem  = addr < A_MEND;
        in_stat = (addr >= A_STAT) && (addr < A_STEND);
        off     = addr - A_STAT;
        cidx    = CIDX_W'(off >> BSEL_W);
        bsel    = BSEL_W'(off);
        snap_ld = rd_en && in_stat && (bsel == '0);
    end

    // Purpose: memory stub writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en && in_mem) begin
            mem_q[addr[MEM_AW-1:0]] <= wdata;
        end
    end

    // Purpose: control bit and DMA address, host write wins over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= 1'b0;
            dma_q <= '0;
        end else begin
            if (wr_en && addr == A_CTRL) inc_q <= wdata[0];
            if (wr_en && addr == A_DLO)      dma_q[7:0]        <= wdata;
            else if (wr_en && addr == A_DHI) dma_q[HBP_AW-1:8] <= wdata;
            else if (dma_step)               dma_q             <= dma_q + 1'b1;
        end
    end

    // Purpose: one free-running statistics counter per increment strobe.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q[g] <= '0;
            else if (cnt_inc[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
        end
    end

    // Purpose: capture a whole counter when its byte 0 is read.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (snap_ld) hold_q <= cnt_q[cidx];
    end

    // Purpose: read data multiplexer.
    always_comb begin
        rdata = '0;
        if (in_mem)              rdata = mem_q[addr[MEM_AW-1:0]];
        else if (addr == A_CTRL) rdata = {7'd0, inc_q};
        else if (addr == A_DLO)  rdata = dma_q[7:0];
        else if (addr == A_DHI)  rdata = dma_q[HBP_AW-1:8];
        else if (in_stat)        rdata = (bsel == '0) ? cnt_q[cidx][7:0]
                                                      : hold_q[8*int'(bsel) +: 8];
    end

    assign dma_inc  = inc_q;
    assign dma_addr = dma_q;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_ld |=> $stable(hold_q)); // R6
endmodule

// File: rtl/hostbyte_port.sv
// Byte-wide host register port, top level.
// It decodes the host select (or the DMA override), keeps the index address,
// and routes accesses into the internal space. It also spots a host write to
// the reset window and registers read data for the ready cycle. It assumes
// host inputs are synchronous to clk. Everything except the pulse generator
// runs on the core reset.
module hostbyte_port
    import hbp_pkg::*;
#(
    parameter int MEM_DEPTH = 64,
    parameter int CTRL_ADDR = 'h0040,
    parameter int STAT_BASE = 'h8000,
    parameter int NUM_CNT   = 4,
    parameter int CNT_W     = 32,
    parameter int WIN_LO    = 'h4000,
    parameter int WIN_HI    = 'h5FFF,
    parameter int PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rnw,
    input  logic [1:0]         reg_sel,
    input  logic               dma_sel_n,
    input  logic [7:0]         host_d_i,
    output logic [7:0]         host_d_o,
    output logic               host_d_oe,
    output logic               rdy_n_o,
    output logic               rdy_oe,
    input  logic [NUM_CNT-1:0] cnt_inc,
    output logic               core_rst_n
);
    localparam logic [HBP_AW-1:0] A_WLO = HBP_AW'(WIN_LO);
    localparam logic [HBP_AW-1:0] A_WHI = HBP_AW'(WIN_HI);

    logic              acc_go, dma_mode, is_data, win_hit;
    logic              int_wr, int_rd, dma_step, dma_inc;
    hsel_e             sel;
    logic [HBP_AW-1:0] idx_q, dma_addr, eff_addr;
    logic [7:0]        int_rdata, rd_mux, rd_q;

    hbp_reset_gen #(.PULSE_LEN(PULSE_LEN)) u_rst (
        .clk(clk), .rst_n(rst_n), .trig(acc_go && win_hit), .core_rst_n(core_rst_n)
    );

    hbp_bus_fsm u_fsm (
        .clk(clk), .rst_n(core_rst_n), .cs_n(cs_n), .rnw(rnw),
        .acc_go(acc_go), .rdy_n_o(rdy_n_o), .rdy_oe(rdy_oe), .data_oe(host_d_oe)
    );

    // Purpose: pick the effective register and internal address.
    always_comb begin
        dma_mode = !dma_sel_n;
        sel      = dma_mode ? (dma_inc ? SEL_DINC : SEL_DATA) : hsel_e'(reg_sel);
        eff_addr = dma_mode ? dma_addr : idx_q;
        is_data  = (sel == SEL_DATA) || (sel == SEL_DINC);
        win_hit  = !dma_mode && is_data && !rnw && (idx_q >= A_WLO) && (idx_q <= A_WHI);
        int_wr   = acc_go && is_data && !rnw && !win_hit;
        int_rd   = acc_go && is_data && rnw;
        dma_step = acc_go && dma_mode && (sel == SEL_DINC);
    end

    hbp_regspace #(
        .MEM_DEPTH(MEM_DEPTH), .CTRL_ADDR(CTRL_ADDR), .STAT_BASE(STAT_BASE),
        .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(core_rst_n), .wr_en(int_wr), .rd_en(int_rd),
        .addr(eff_addr), .wdata(host_d_i), .rdata(int_rdata),
        .dma_step(dma_step), .dma_inc(dma_inc), .dma_addr(dma_addr), .cnt_inc(cnt_inc)
    );

    // Purpose: index address register writes and post-increment.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            idx_q <= '0;
        end else if (acc_go && !dma_mode) begin
            unique case (sel)
                SEL_ALO:  if (!rnw) idx_q[7:0]        <= host_d_i;
                SEL_AHI:  if (!rnw) idx_q[HBP_AW-1:8] <= host_d_i;
                SEL_DINC: idx_q <= idx_q + 1'b1;
                default:  idx_q <= idx_q;
            endcase
        end
    end

    // Purpose: choose read data by effective register.
    always_comb begin
        unique case (sel)
            SEL_ALO: rd_mux = idx_q[7:0];
            SEL_AHI: rd_mux = idx_q[HBP_AW-1:8];
            default: rd_mux = int_rdata;
        endcase
    end

    // Purpose: hold read data for the ready cycle.
    always_ff @(posedge clk) begin
        if (!core_rst_n)           rd_q <= '0;
        else if (acc_go && rnw)    rd_q <= rd_mux;
    end

    assign host_d_o = rd_q;

    AST_DMA_IDX_KEEP: assert property (@(posedge clk) disable iff (!core_rst_n)
        (acc_go && dma_mode) |=> $stable(idx_q)); // R4
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!core_rst_n)
        (acc_go && !dma_mode && sel == SEL_DINC && !win_hit)
        |=> (idx_q == $past(idx_q) + 1'b1)); // R3
    AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk)
        !core_rst_n |-> (!rdy_oe && !host_d_oe)); // R10
endmodule

// File: tb/hostbyte_port_tb.sv
`timescale 1ns/1ps
module hostbyte_port_tb;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rnw = 1'b1, dma_sel_n = 1'b1;
    logic [1:0] reg_sel = 2'b00;
    logic [7:0] host_d_i = '0;
    logic [NC-1:0] cnt_inc = '0;
    logic [7:0] host_d_o;
    logic host_d_oe, rdy_n_o, rdy_oe, core_rst_n;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl [64];
    int unsigned cnt_mdl [NC];

    always #2.5 clk = ~clk;

    hostbyte_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rnw(rnw), .reg_sel(reg_sel),
        .dma_sel_n(dma_sel_n), .host_d_i(host_d_i), .host_d_o(host_d_o),
        .host_d_oe(host_d_oe), .rdy_n_o(rdy_n_o), .rdy_oe(rdy_oe),
        .cnt_inc(cnt_inc), .core_rst_n(core_rst_n)
    );

    function automatic logic [7:0] cbyte(int unsigned v, int b);
        return 8'((v >> (8 * b)) & 32'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One host access with handshake check; returns read data.
    task automatic acc(input logic r, input logic [1:0] s, input logic dm,
                       input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        cs_n = 1'b0; rnw = r; reg_sel = s; dma_sel_n = !dm; host_d_i = wd;
        @(negedge clk);
        rd = host_d_o;
        check(rdy_oe && !rdy_n_o && (host_d_oe == r), "R9 ack",
              {rdy_oe, rdy_n_o, host_d_oe}, {1'b1, 1'b0, r});
        cs_n = 1'b1;
        @(negedge clk);
        check(rdy_oe && rdy_n_o && !host_d_oe, "R9 high",
              {rdy_oe, rdy_n_o, host_d_oe}, 3'b110);
        @(negedge clk);
        check(!rdy_oe, "R9 release", rdy_oe, 0);
        dma_sel_n = 1'b1;
    endtask

    task automatic set_idx(input logic [15:0] a);
        logic [7:0] d;
        acc(1'b0, 2'b00, 1'b0, a[7:0], d);
        acc(1'b0, 2'b01, 1'b0, a[15:8], d);
    endtask

    task automatic get_idx(output logic [15:0] a);
        logic [7:0] lo, hi;
        acc(1'b1, 2'b00, 1'b0, 8'h00, lo);
        acc(1'b1, 2'b01, 1'b0, 8'h00, hi);
        a = {hi, lo};
    endtask

    task automatic wr_at(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] x;
        set_idx(a);
        acc(1'b0, 2'b10, 1'b0, d, x);
    endtask

    task automatic rd_at(input logic [15:0] a, output logic [7:0] d);
        set_idx(a);
        acc(1'b1, 2'b10, 1'b0, 8'h00, d);
    endtask

    task automatic pulse_cnt(input int i, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cnt_inc[i] = 1'b1;
            @(negedge clk); cnt_inc[i] = 1'b0;
            cnt_mdl[i]++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d, snap0;
        logic [15:0] ia;
        int unsigned snap;
        int lowc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        for (int i = 0; i < NC; i++) cnt_mdl[i] = 0;

        // R10: no drive during hardware reset, even with chip select low
        cs_n = 1'b0; rnw = 1'b1;
        repeat (4) @(negedge clk);
        check(!rdy_oe && !host_d_oe && !core_rst_n, "R10 hw reset",
              {rdy_oe, host_d_oe, core_rst_n}, 0);
        cs_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset value and write/read of index bytes
        get_idx(ia);
        check(ia == 16'h0000, "R1 reset index", ia, 0);
        set_idx(16'hBEEF);
        get_idx(ia);
        check(ia == 16'hBEEF, "R1 index readback", ia, 16'hBEEF);

        // R3: post-increment wrap at 0xFFFF
        set_idx(16'hFFFF);
        acc(1'b1, 2'b11, 1'b0, 8'h00, d);
        get_idx(ia);
        check(ia == 16'h0000, "R3 wrap", ia, 0);

        // R2/R3: random mix against a bench model
        for (int k = 0; k < 120; k++) begin
            int op = $urandom_range(0, 2);
            logic [15:0] a = 16'($urandom_range(0, 60));
            logic [7:0] wd = 8'($urandom_range(0, 255));
            if (op == 0) begin
                wr_at(a, wd); mdl[a] = wd;
                get_idx(ia);
                check(ia == a, "R2 index kept", ia, a);
            end else if (op == 1) begin
                rd_at(a, d);
                check(d == mdl[a], "R2 read", d, mdl[a]);
            end else begin
                set_idx(a);
                for (int j = 0; j < 3; j++) begin
                    wd = 8'($urandom_range(0, 255));
                    acc(1'b0, 2'b11, 1'b0, wd, d);
                    mdl[a + 16'(j)] = wd;
                end
                get_idx(ia);
                check(ia == a + 16'd3, "R3 burst step", ia, a + 3);
                set_idx(a);
                acc(1'b1, 2'b11, 1'b0, 8'h00, d);
                check(d == mdl[a], "R3 inc read", d, mdl[a]);
            end
        end

        // R4: DMA without increment; select pins set to a value that would move the index
        wr_at(16'h0040, 8'h00);
        wr_at(16'h0041, 8'h10);
        wr_at(16'h0042, 8'h00);
        set_idx(16'h0005);
        acc(1'b0, 2'b11, 1'b1, 8'hA5, d); mdl[16'h10] = 8'hA5;
        acc(1'b0, 2'b00, 1'b1, 8'h5A, d); mdl[16'h10] = 8'h5A;
        get_idx(ia);
        check(ia == 16'h0005, "R4 index untouched", ia, 5);
        rd_at(16'h0010, d);
        check(d == 8'h5A, "R4 DMA write target", d, 8'h5A);
        rd_at(16'h0041, d);
        check(d == 8'h10, "R4 DMA addr kept", d, 8'h10);

        // R5: DMA with increment
        wr_at(16'h0040, 8'h01);
        for (int j = 0; j < 3; j++) begin
            acc(1'b0, 2'($urandom_range(0, 3)), 1'b1, 8'(8'hC0 + j), d);
            mdl[16'h10 + j] = 8'(8'hC0 + j);
        end
        rd_at(16'h0041, d);
        check(d == 8'h13, "R5 DMA addr stepped", d, 8'h13);
        rd_at(16'h0012, d);
        check(d == 8'hC2, "R5 DMA data", d, 8'hC2);
        acc(1'b1, 2'b01, 1'b1, 8'h00, d);
        check(d == mdl[16'h13], "R5 DMA read", d, mdl[16'h13]);

        // R6: counter snapshot across a carry into byte 1
        pulse_cnt(1, 300);
        set_idx(16'h8004);
        acc(1'b1, 2'b11, 1'b0, 8'h00, snap0);
        snap = cnt_mdl[1];
        check(snap0 == cbyte(snap, 0), "R6 byte0 live", snap0, cbyte(snap, 0));
        pulse_cnt(1, 260);
        for (int b = 1; b < 4; b++) begin
            acc(1'b1, 2'b11, 1'b0, 8'h00, d);
            check(d == cbyte(snap, b), "R6 held byte", d, cbyte(snap, b));
        end
        wr_at(16'h8004, 8'hFF);
        rd_at(16'h8004, d);
        check(d == cbyte(cnt_mdl[1], 0), "R6 write ignored", d, cbyte(cnt_mdl[1], 0));
        rd_at(16'h8005, d);
        check(d == cbyte(cnt_mdl[1], 1), "R6 new snapshot", d, cbyte(cnt_mdl[1], 1));

        // R8: DMA write into the reset window
        wr_at(16'h0040, 8'h00);
        wr_at(16'h0041, 8'h00);
        wr_at(16'h0042, 8'h40);
        acc(1'b0, 2'b10, 1'b1, 8'h77, d);
        repeat (2) @(negedge clk);
        check(core_rst_n == 1'b1, "R8 no reset", core_rst_n, 1);
        rd_at(16'h0010, d);
        check(d == mdl[16'h10], "R8 state kept", d, mdl[16'h10]);

        // R7/R10: host write into the reset window
        set_idx(16'h4ABC);
        @(negedge clk);
        cs_n = 1'b0; rnw = 1'b0; reg_sel = 2'b10; host_d_i = 8'h11;
        @(negedge clk);
        check(!rdy_oe && !host_d_oe, "R10 pulse no drive", {rdy_oe, host_d_oe}, 0);
        cs_n = 1'b1;
        lowc = core_rst_n ? 0 : 1;
        for (int k = 0; k < 40 && !core_rst_n; k++) begin
            @(negedge clk);
            if (!core_rst_n) lowc++;
        end
        check(lowc == 16, "R7 pulse length", lowc, 16);
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        cnt_mdl[1] = 0;
        get_idx(ia);
        check(ia == 16'h0000, "R7 index cleared", ia, 0);
        rd_at(16'h0010, d);
        check(d == 8'h00, "R7 memory cleared", d, 0);
        rd_at(16'h8004, d);
        check(d == 8'h00, "R7 counter cleared", d, 0);
        rd_at(16'h0042, d);
        check(d == 8'h00, "R7 DMA addr cleared", d, 0);

        summary();
        $finish;
    end
endmodule